// File: doc/BRIEF.md
# Program Memory Block Protection Unit

This unit sits between a processor's table-access port and a flash-style program array and decides, access by access, whether a table read or a table write may proceed. The array is split into a small boot region at the bottom and a set of equal-sized user regions above it. Each region carries three active-low protection flags: one that forbids table writes, one that hides the region from table reads issued by code that runs elsewhere, and one that gates the external programming port only.

A table write is passed to the array through `mem_we` only when the target region allows it. A table read is latched one cycle later into `rd_data`. If the read is refused, zeros are returned and `rd_zeroed` is set. Code that runs inside a region may always read that region. The protection flags are held in six configuration bytes inside the table address space. A table write can clear a flag but never set one. Only an erase request from the programming path sets flags again, either for one region or for the whole device.

Top module: `pmem_guard`

## Requirements
- R1: The boot region covers byte addresses 0x000000 to 0x0007FF. User region k (k < USER_BLOCKS, default 4) covers addresses whose bits [21:14] equal k, excluding the boot range, so region 0 is 0x000800 to 0x003FFF and region 1 starts at 0x004000. Any address at or above USER_BLOCKS*0x4000 that is not a configuration byte is unprotected.
- R2: When the target region's write flag is 0, a table write keeps `mem_we` low, whatever `pc` is. Otherwise a table write to array space drives `mem_we` high in the same cycle.
- R3: When the target region's read flag is 0 and `pc` lies in a different region, a table read loads `rd_data` = 0 and `rd_zeroed` = 1 at the next rising edge.
- R4: When `pc` lies in the same region as the target, a table read loads `mem_rdata` into `rd_data` with `rd_zeroed` = 0, even if that region's read flag is 0.
- R5: Code-protect flags have no effect on table accesses. `ext_allow` is 1 exactly when the code-protect flag of the region holding `ext_addr` is 1, or when that address is unprotected.
- R6: The configuration bytes are at 0x300008 to 0x30000D. They hold: offset 0, code-protect for regions 0-7 in bits 0-7; offset 1, data code-protect in bit 7 and boot code-protect in bit 6; offset 2, write flags for regions 0-7; offset 3, data write flag in bit 7, boot write flag in bit 6 and configuration write flag in bit 5; offset 4, read flags for regions 0-7; offset 5, boot read flag in bit 6.
- R7: A table write to a configuration byte replaces each flag with (old AND written bit). A flag at 0 stays 0.
- R8: While the configuration write flag (offset 3 bit 5) is 0, table writes to configuration bytes change nothing.
- R9: `erase_req` with `erase_all` sets every flag to 1. With `erase_boot` it sets only the three boot flags. Otherwise it sets the three flags of region `erase_idx`. In the cycle of an erase, a configuration write is ignored.
- R10: Unused bit positions, and flags of regions at or above USER_BLOCKS, always read as 1 and cannot be cleared.
- R11: After reset every flag is 1, `rd_data` is 0 and `rd_zeroed` is 0.
- R12: A table write to a configuration byte never raises `mem_we`. A table read of a configuration byte returns the byte with `rd_zeroed` = 0, whatever the read flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_rd | input | 1 | Table read strobe |
| tbl_wr | input | 1 | Table write strobe |
| tbl_addr | input | ADDR_W | Table pointer (byte address) |
| pc | input | ADDR_W | Address of the instruction issuing the access |
| tbl_wdata | input | 8 | Table write data |
| mem_rdata | input | 8 | Array data at `tbl_addr` |
| mem_we | output | 1 | Write enable to the array |
| rd_data | output | 8 | Registered table read result |
| rd_zeroed | output | 1 | Last table read was refused |
| ext_addr | input | ADDR_W | Address presented by the programming port |
| ext_allow | output | 1 | Programming port may access `ext_addr` |
| erase_req | input | 1 | Erase request |
| erase_all | input | 1 | Erase applies to the whole device |
| erase_boot | input | 1 | Block erase of the boot region |
| erase_idx | input | 3 | User region index for a block erase |

## Verification
The directed cases probe region edges (0x07FF/0x0800, 0x3FFF/0x4000) and the first unprotected address. A design that misdecodes these lets a write land in a locked region or locks a free one. Reads of a locked region are issued both from inside it and from other regions: a design that ignores `pc` either leaks data to outside code or starves the region's own code. Configuration writes try to set cleared flags, clear unused bits, and race an erase in the same cycle. A wrong design would re-arm flags by software, report 0 in unused positions, or lose the erase. Randomized traffic with a reference model then mixes these under shifting flag states, including a locked configuration write flag.

// File: rtl/pmem_guard.sv
module pmem_guard #(
  parameter int ADDR_W      = 22,
  parameter int USER_BLOCKS = 4,
  parameter int BLK_SHIFT   = 14,
  parameter int BOOT_END    = 'h800,
  parameter int CFG_BASE    = 'h300008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_rd,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [7:0]        tbl_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [7:0]        rd_data,
  output logic              rd_zeroed,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              ext_allow,
  input  logic              erase_req,
  input  logic              erase_all,
  input  logic              erase_boot,
  input  logic [2:0]        erase_idx
);
  localparam int IW = ADDR_W - BLK_SHIFT;
  localparam logic [7:0] UMASK = 8'((1 << USER_BLOCKS) - 1);
  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_END);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 6);

  logic [7:0] cp, wrt, ebtr;
  logic       cpd, cpb, wrtd, wrtb, wrtc, ebtrb;

  // target decode
  wire [IW-1:0] t_hi   = tbl_addr[ADDR_W-1:BLK_SHIFT];
  wire          t_boot = tbl_addr < BOOT_LIM;
  wire          t_impl = !t_boot && (t_hi < IW'(USER_BLOCKS));
  wire [2:0]    t_sel  = t_hi[2:0];
  wire          t_cfg  = (tbl_addr >= CFG_LO) && (tbl_addr < CFG_HI);
  wire [2:0]    c_off  = 3'(tbl_addr - CFG_LO);

  // issuing instruction decode
  wire [IW-1:0] p_hi   = pc[ADDR_W-1:BLK_SHIFT];
  wire          p_boot = pc < BOOT_LIM;
  wire          same   = (t_boot && p_boot) || (!t_boot && !p_boot && t_hi == p_hi);

  // programming port decode
  wire [IW-1:0] e_hi   = ext_addr[ADDR_W-1:BLK_SHIFT];
  wire          e_boot = ext_addr < BOOT_LIM;
  wire          e_impl = !e_boot && (e_hi < IW'(USER_BLOCKS));

  wire wrt_t  = t_boot ? wrtb  : (t_impl ? wrt[t_sel]  : 1'b1);
  wire ebtr_t = t_boot ? ebtrb : (t_impl ? ebtr[t_sel] : 1'b1);

  wire allow_read = t_cfg || ebtr_t || same;
  wire cfg_we     = tbl_wr && t_cfg && wrtc && !erase_req;

  assign mem_we    = tbl_wr && !t_cfg && wrt_t;
  assign ext_allow = e_boot ? cpb : (e_impl ? cp[e_hi[2:0]] : 1'b1);

  logic [7:0] cfg_rd;
  always_comb begin
    case (c_off)
      3'd0:    cfg_rd = cp;
      3'd1:    cfg_rd = {cpd, cpb, 6'h3F};
      3'd2:    cfg_rd = wrt;
      3'd3:    cfg_rd = {wrtd, wrtb, wrtc, 5'h1F};
      3'd4:    cfg_rd = ebtr;
      3'd5:    cfg_rd = {1'b1, ebtrb, 6'h3F};
      default: cfg_rd = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp <= 8'hFF; wrt <= 8'hFF; ebtr <= 8'hFF;
      cpd <= 1'b1; cpb <= 1'b1; wrtd <= 1'b1; wrtb <= 1'b1; wrtc <= 1'b1; ebtrb <= 1'b1;
      rd_data <= 8'h00;
      rd_zeroed <= 1'b0;
    end else begin
      if (erase_req) begin
        if (erase_all) begin
          cp <= 8'hFF; wrt <= 8'hFF; ebtr <= 8'hFF;
          cpd <= 1'b1; cpb <= 1'b1; wrtd <= 1'b1; wrtb <= 1'b1; wrtc <= 1'b1; ebtrb <= 1'b1;
        end else if (erase_boot) begin
          cpb <= 1'b1; wrtb <= 1'b1; ebtrb <= 1'b1;
        end else begin
          cp[erase_idx] <= 1'b1; wrt[erase_idx] <= 1'b1; ebtr[erase_idx] <= 1'b1;
        end
      end else if (cfg_we) begin
        case (c_off)
          3'd0: cp <= cp & (tbl_wdata | ~UMASK);
          3'd1: begin cpd <= cpd & tbl_wdata[7]; cpb <= cpb & tbl_wdata[6]; end
          3'd2: wrt <= wrt & (tbl_wdata | ~UMASK);
          3'd3: begin
            wrtd <= wrtd & tbl_wdata[7];
            wrtb <= wrtb & tbl_wdata[6];
            wrtc <= wrtc & tbl_wdata[5];
          end
          3'd4: ebtr <= ebtr & (tbl_wdata | ~UMASK);
          3'd5: ebtrb <= ebtrb & tbl_wdata[6];
          default: ;
        endcase
      end
      if (tbl_rd) begin
        rd_zeroed <= !allow_read;
        rd_data   <= !allow_read ? 8'h00 : (t_cfg ? cfg_rd : mem_rdata);
      end
    end
  end

  assert_boot_wr_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr && t_boot && !wrtb) |-> !mem_we);

  assert_zero_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zeroed |-> (rd_data == 8'h00));

  assert_own_region_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && !t_cfg && same) |=> !rd_zeroed);

  assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_req |=> (((cp & ~$past(cp)) == 8'h00) && ((wrt & ~$past(wrt)) == 8'h00)
                    && ((ebtr & ~$past(ebtr)) == 8'h00)));

  assert_cfg_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrtc && !erase_req) |=> ($stable(cp) && $stable(wrt) && $stable(ebtr) && $stable(ebtrb)));

  assert_full_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_all) |=> (&{cp, wrt, ebtr, cpd, cpb, wrtd, wrtb, wrtc, ebtrb}));

  assert_unused_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp & wrt & ebtr & ~UMASK) == ~UMASK));

  assert_cfg_no_array_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr && t_cfg) |-> !mem_we);
endmodule

// File: tb/pmem_guard_tb.sv
module pmem_guard_tb;
  localparam int CLK_NS = 10;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_rd = 0, tbl_wr = 0;
  logic [21:0] tbl_addr = '0, pc = '0, ext_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [7:0] mem_rdata;
  logic mem_we, rd_zeroed, ext_allow;
  logic [7:0] rd_data;
  logic erase_req = 0, erase_all = 0, erase_boot = 0;
  logic [2:0] erase_idx = '0;

  int vectors = 0, misses = 0;
  bit done = 0;

  logic [7:0] m_cp, m_wrt, m_ebtr;
  logic m_cpd, m_cpb, m_wrtd, m_wrtb, m_wrtc, m_ebtrb;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = memf(tbl_addr);

  pmem_guard u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_rd(tbl_rd), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
    .pc(pc), .tbl_wdata(tbl_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .rd_data(rd_data), .rd_zeroed(rd_zeroed), .ext_addr(ext_addr), .ext_allow(ext_allow),
    .erase_req(erase_req), .erase_all(erase_all), .erase_boot(erase_boot), .erase_idx(erase_idx)
  );

  function automatic int region(input logic [21:0] a);
    if (a < 22'h800) return -1;
    return int'(a >> 14);
  endfunction

  function automatic bit is_cfg(input logic [21:0] a);
    return a >= 22'h300008 && a <= 22'h30000D;
  endfunction

  function automatic bit flag_of(input logic [21:0] a, input logic [7:0] v, input logic b);
    int r = region(a);
    if (r == -1) return b;
    if (r < NB) return v[r];
    return 1'b1;
  endfunction

  function automatic logic [7:0] cfg_byte(input int off);
    logic [7:0] um = 8'hFF << NB;
    case (off)
      0: return m_cp | um;
      1: return {m_cpd, m_cpb, 6'h3F};
      2: return m_wrt | um;
      3: return {m_wrtd, m_wrtb, m_wrtc, 5'h1F};
      4: return m_ebtr | um;
      default: return {1'b1, m_ebtrb, 6'h3F};
    endcase
  endfunction

  task automatic model_all_ones();
    m_cp = 8'hFF; m_wrt = 8'hFF; m_ebtr = 8'hFF;
    m_cpd = 1; m_cpb = 1; m_wrtd = 1; m_wrtb = 1; m_wrtc = 1; m_ebtrb = 1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input logic [21:0] a, input logic [21:0] p,
                    input logic [7:0] wd, input logic [21:0] ea,
                    input bit er, input bit eall, input bit eboot, input logic [2:0] eidx);
    logic [7:0] exp_d; bit exp_z; bit exp_we; string rtag;
    @(negedge clk);
    tbl_rd = rd; tbl_wr = wr; tbl_addr = a; pc = p; tbl_wdata = wd; ext_addr = ea;
    erase_req = er; erase_all = eall; erase_boot = eboot; erase_idx = eidx;
    #1;
    exp_we = wr && !is_cfg(a) && flag_of(a, m_wrt, m_wrtb);
    if (wr) check(is_cfg(a) ? "R12" : "R2", {7'd0, mem_we}, {7'd0, exp_we});
    check("R5", {7'd0, ext_allow}, {7'd0, flag_of(ea, m_cp, m_cpb)});
    if (is_cfg(a)) begin exp_d = cfg_byte(int'(a - 22'h300008)); exp_z = 0; rtag = "R12"; end
    else if (flag_of(a, m_ebtr, m_ebtrb) || region(a) == region(p)) begin
      exp_d = memf(a); exp_z = 0; rtag = flag_of(a, m_ebtr, m_ebtrb) ? "R1" : "R4";
    end else begin exp_d = 8'h00; exp_z = 1; rtag = "R3"; end
    @(posedge clk);
    #1;
    if (rd) begin
      check(rtag, rd_data, exp_d);
      check(rtag, {7'd0, rd_zeroed}, {7'd0, exp_z});
    end
    if (er) begin
      if (eall) model_all_ones();
      else if (eboot) begin m_cpb = 1; m_wrtb = 1; m_ebtrb = 1; end
      else begin m_cp[eidx] = 1; m_wrt[eidx] = 1; m_ebtr[eidx] = 1; end
    end else if (wr && is_cfg(a) && m_wrtc) begin
      case (int'(a - 22'h300008))
        0: m_cp &= wd;
        1: begin m_cpd &= wd[7]; m_cpb &= wd[6]; end
        2: m_wrt &= wd;
        3: begin m_wrtd &= wd[7]; m_wrtb &= wd[6]; m_wrtc &= wd[5]; end
        4: m_ebtr &= wd;
        default: m_ebtrb &= wd[6];
      endcase
      m_cp |= 8'hFF << NB; m_wrt |= 8'hFF << NB; m_ebtr |= 8'hFF << NB;
    end
    tbl_rd = 0; tbl_wr = 0; erase_req = 0; erase_all = 0; erase_boot = 0;
  endtask

  task automatic rd(input logic [21:0] a, input logic [21:0] p);
    op(1, 0, a, p, 8'h00, 22'h0, 0, 0, 0, 3'd0);
  endtask
  task automatic wr(input logic [21:0] a, input logic [21:0] p, input logic [7:0] d);
    op(0, 1, a, p, d, 22'h0, 0, 0, 0, 3'd0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_all_ones();
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", rd_data, 8'h00);
    check("R11", {7'd0, rd_zeroed}, 8'h00);
    rst_n = 1'b1;
    // R6 R11: every configuration byte reads all ones
    for (int i = 0; i < 6; i++) rd(22'h300008 + 22'(i), 22'h100);
    // R7: clear region 0 write flag, then try to set it back
    wr(22'h30000A, 22'h100, 8'hFE);
    wr(22'h30000A, 22'h100, 8'hFF);
    rd(22'h30000A, 22'h100);
    // R2: region 0 locked for writes from inside and outside
    wr(22'h000900, 22'h003FFE, 8'h11);
    wr(22'h000900, 22'h00BFFE, 8'h11);
    // R1 region edges
    wr(22'h0007FF, 22'h0, 8'h22);
    wr(22'h000800, 22'h0, 8'h22);
    wr(22'h003FFF, 22'h0, 8'h22);
    wr(22'h004000, 22'h0, 8'h22);
    wr(22'h010000, 22'h0, 8'h22);
    // R3 R4: region 0 hidden from outside readers
    wr(22'h30000C, 22'h100, 8'hFE);
    rd(22'h0008FF, 22'h007FFE);
    rd(22'h0008FF, 22'h003FFE);
    rd(22'h0008FF, 22'h000100);
    rd(22'h003FFF, 22'h004000);
    // R10: unused positions cannot be cleared
    wr(22'h300008, 22'h100, 8'h00);
    rd(22'h300008, 22'h100);
    // R5: code-protect cleared, table reads unaffected, port gated
    rd(22'h004000, 22'h000100);
    op(0, 0, 22'h0, 22'h0, 8'h0, 22'h004000, 0, 0, 0, 3'd0);
    op(0, 0, 22'h0, 22'h0, 8'h0, 22'h000100, 0, 0, 0, 3'd0);
    // boot read protect
    wr(22'h30000D, 22'h100, 8'hBF);
    rd(22'h000010, 22'h005000);
    rd(22'h000010, 22'h000700);
    rd(22'h010000, 22'h000000);
    // R9: block erase of region 0 wins over a same-cycle config write
    op(0, 1, 22'h30000A, 22'h100, 8'h00, 22'h0, 1, 0, 0, 3'd0);
    rd(22'h30000A, 22'h100);
    rd(22'h30000C, 22'h100);
    // R9 boot erase
    op(0, 0, 22'h0, 22'h0, 8'h0, 22'h0, 1, 0, 1, 3'd0);
    rd(22'h30000D, 22'h100);
    // R8: lock config writes
    wr(22'h30000B, 22'h100, 8'hDF);
    wr(22'h30000A, 22'h100, 8'h00);
    rd(22'h30000A, 22'h100);
    rd(22'h30000B, 22'h100);
    // R9 full erase
    op(0, 0, 22'h0, 22'h0, 8'h0, 22'h0, 1, 1, 0, 3'd0);
    for (int i = 0; i < 6; i++) rd(22'h300008 + 22'(i), 22'h100);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int k = int'($urandom_range(0, 99));
      logic [21:0] a = 22'($urandom_range(0, 'h17FFF));
      logic [21:0] p = ($urandom_range(0, 1) == 1) ? (a ^ 22'($urandom_range(0, 'h7F)))
                                                   : 22'($urandom_range(0, 'h17FFF));
      logic [21:0] ea = 22'($urandom_range(0, 'h17FFF));
      logic [21:0] ca = 22'h300008 + 22'($urandom_range(0, 5));
      logic [7:0] d = 8'($urandom) | 8'($urandom);
      if (k < 40) op(1, 0, a, p, 8'h0, ea, 0, 0, 0, 3'd0);
      else if (k < 70) op(0, 1, a, p, d, ea, 0, 0, 0, 3'd0);
      else if (k < 85) op(0, 1, ca, p, d, ea, 0, 0, 0, 3'd0);
      else if (k < 93) op(1, 0, ca, p, 8'h0, ea, 0, 0, 0, 3'd0);
      else if (k < 98) op(0, 0, a, p, 8'h0, ea, 1, 0, $urandom_range(0, 3) == 0, 3'($urandom));
      else op(0, 0, a, p, 8'h0, ea, 1, 1, 0, 3'd0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule